// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a clocked host and an external 1M x 16 asynchronous static RAM. The host presents a one-cycle request made of a read/write flag, a 20-bit word address, 16 bits of write data and a two-bit lane mask. The controller then plays out the strobe sequence the memory needs and reports completion with a one-cycle done pulse. For reads, the captured word comes back on the same cycle as done.

Each strobe phase is a whole number of clock cycles. These counts are worked out at elaboration from the clock period parameter and from separate nanosecond minimums: cycle time, access time, output-enable access, write pulse, address-to-end-of-write, data-to-end-of-write and bus release. The data bus leaves the block as a lane-split output, a per-lane drive enable and an input. The pad ring turns these into the shared bidirectional pins. The controller never drives a lane while the memory may be driving it.

Top module: `sram16_strobe_ctrl`

## Requirements
- R1: After reset and whenever idle, the controller holds mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n and mem_ub_n high and mem_dq_oe at 0, and ready is high. mem_cs is driven high from the first clock after reset.
- R2: A phase of minimum t ns lasts ceil(t/CLK_PERIOD_NS) cycles. The chip stays selected for at least ceil(70/CLK_PERIOD_NS) cycles per access. The phase counter is never reloaded before it runs out.
- R3: mem_we_n is low only while mem_cs_n is low, mem_cs is high and at least one byte select is low. It stays low for exactly max(ceil(50/P), ceil(30/P)) cycles. Address and selects are active for at least ceil(60/P) cycles before it rises.
- R4: Write data is driven for at least ceil(30/P) cycles before mem_we_n rises, and is still driven in the cycle after it rises.
- R5: A read holds mem_oe_n low for max(ceil(70/P), ceil(35/P)) cycles and captures mem_dq_i on the last of them. No lane is driven while mem_oe_n is low. rd_data holds between captures.
- R6: Lane mask bit 0 selects bits 7:0 (mem_lb_n low) and bit 1 selects bits 15:8 (mem_ub_n low). On writes, only selected lanes are driven. On reads, unselected lanes of rd_data return zero.
- R7: A request with lane mask 00 keeps both byte selects high and never lowers mem_we_n, so memory is left untouched. It still completes with a done pulse.
- R8: After mem_oe_n rises at the end of a read, no lane is driven for at least floor(25/P)+1 cycles. Done for that read comes only after this gap.
- R9: ready is low from the cycle after a request is accepted until done. A request presented while ready is low is ignored.
- R10: done is a single-cycle pulse. ready rises only together with done. Latency from accept to done is write setup + write pulse + write recovery cycles for a write, and read length + turnaround cycles for a read.
- R11: mem_addr stays constant while the chip is selected. The chip is deselected for at least one cycle between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe, taken when ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ready | output | 1 | High when a request can be accepted |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with done |
| mem_addr | output | 20 | Memory address pins |
| mem_cs_n | output | 1 | Low-active chip select |
| mem_cs | output | 1 | High-active chip select |
| mem_we_n | output | 1 | Write enable, low active |
| mem_oe_n | output | 1 | Output enable, low active |
| mem_lb_n | output | 1 | Lower byte select, low active |
| mem_ub_n | output | 1 | Upper byte select, low active |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 2 | Per-lane drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from the memory pins |

## Verification
The bench puts a read directly before a write, so the bus turnaround is exercised. A design that cut the gap short would start driving while the memory is still releasing, which the bench reports as a short no-drive interval. Single-lane writes and reads check that lanes are isolated. A swapped or leaking lane would corrupt the other byte, or return noise where zero is expected. A zero-mask write followed by a read-back catches a controller that strobes WE with no byte selected. Measured widths of the write pulse, the setup before its end and the output-enable window catch a miscounted phase. A request fired while busy, and a reset in the middle of a write, show whether stray requests leak through and whether the strobes fall back to idle.

// File: rtl/sram16_pkg.sv
package sram16_pkg;

    parameter int ADDR_W = 20;
    parameter int DATA_W = 16;
    parameter int LANE_W = 8;
    localparam int LANES = DATA_W / LANE_W;

    // Cycles needed to cover at least ns nanoseconds.
    function automatic int cyc_cover(input int ns, input int per);
        if (per <= 0) return 1;
        return (ns + per - 1) / per;
    endfunction

    // Cycles needed to exceed ns nanoseconds strictly.
    function automatic int cyc_exceed(input int ns, input int per);
        if (per <= 0) return 1;
        return ns / per + 1;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WSETUP,
        PH_WPULSE,
        PH_WREC,
        PH_READ,
        PH_TURN
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [LANES-1:0]    lanes;
        logic                done;
        logic                cs_n;
        logic                cs;
        logic                we_n;
        logic                oe_n;
        logic [LANES-1:0]    bsel_n;
        logic [LANES-1:0]    drv;
    } ctrl_s;

endpackage

// File: rtl/sram16_phase_timer.sv
module sram16_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    AST_NO_EARLY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> zero) else $error("phase counter reloaded before expiry"); // R2

endmodule

// File: rtl/sram16_lane_io.sv
module sram16_lane_io
    import sram16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [LANES-1:0]  lanes,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  drv,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic [LANES-1:0]  dq_oe,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] rdata_d, rdata_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dq_o[g*LANE_W +: LANE_W]  = wdata[g*LANE_W +: LANE_W];
        assign dq_oe[g]                  = drv[g];
        always_comb begin
            rdata_d[g*LANE_W +: LANE_W] = rdata_q[g*LANE_W +: LANE_W];
            if (capture) begin
                rdata_d[g*LANE_W +: LANE_W] = lanes[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rdata)) else $error("read data moved without capture"); // R5

endmodule

// File: rtl/sram16_strobe_ctrl.sv
module sram16_strobe_ctrl
    import sram16_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_CYCLE_NS    = 70,
    parameter int T_ACCESS_NS   = 70,
    parameter int T_OE_NS       = 35,
    parameter int T_WP_NS       = 50,
    parameter int T_AW_NS       = 60,
    parameter int T_DW_NS       = 30,
    parameter int T_HZ_NS       = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_lanes,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [LANES-1:0]  mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    // Phase lengths in cycles, fixed at elaboration.
    localparam int N_CYC  = cyc_cover(T_CYCLE_NS,  CLK_PERIOD_NS);
    localparam int N_AA   = cyc_cover(T_ACCESS_NS, CLK_PERIOD_NS);
    localparam int N_OE   = cyc_cover(T_OE_NS,     CLK_PERIOD_NS);
    localparam int N_WP   = cyc_cover(T_WP_NS,     CLK_PERIOD_NS);
    localparam int N_AW   = cyc_cover(T_AW_NS,     CLK_PERIOD_NS);
    localparam int N_DW   = cyc_cover(T_DW_NS,     CLK_PERIOD_NS);
    localparam int N_TA   = cyc_exceed(T_HZ_NS,    CLK_PERIOD_NS);
    localparam int W_LO   = imax(N_WP, N_DW);
    localparam int W_SU   = (N_AW > W_LO) ? (N_AW - W_LO) : 0;
    localparam int W_REC  = (N_CYC > W_SU + W_LO) ? (N_CYC - W_SU - W_LO) : 1;
    localparam int R_LEN  = imax(N_CYC, imax(N_AA, N_OE));
    localparam int MAXLEN = imax(imax(W_LO, W_SU), imax(imax(W_REC, R_LEN), N_TA));
    localparam int CNT_W  = $clog2(MAXLEN + 1);
    localparam logic [CNT_W-1:0] LD_WSU = CNT_W'((W_SU > 0) ? W_SU - 1 : 0);
    localparam logic [CNT_W-1:0] LD_WLO = CNT_W'(W_LO - 1);
    localparam logic [CNT_W-1:0] LD_WREC = CNT_W'(W_REC - 1);
    localparam logic [CNT_W-1:0] LD_READ = CNT_W'(R_LEN - 1);
    localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(N_TA - 1);

    if (CLK_PERIOD_NS <= 0) begin : g_bad_period
        $error("CLK_PERIOD_NS must be positive");
    end

    ctrl_s            r_d, r_q;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_zero;
    logic             capture;

    sram16_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.cs   = 1'b1;
        t_load   = 1'b0;
        t_val    = '0;
        capture  = 1'b0;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    r_d.addr   = req_addr;
                    r_d.wdata  = req_wdata;
                    r_d.lanes  = req_lanes;
                    r_d.cs_n   = 1'b0;
                    r_d.bsel_n = ~req_lanes;
                    t_load     = 1'b1;
                    if (req_write) begin
                        r_d.drv = req_lanes;
                        if (W_SU > 0) begin
                            r_d.phase = PH_WSETUP;
                            t_val     = LD_WSU;
                        end else begin
                            r_d.phase = PH_WPULSE;
                            r_d.we_n  = ~(|req_lanes);
                            t_val     = LD_WLO;
                        end
                    end else begin
                        r_d.phase = PH_READ;
                        r_d.oe_n  = 1'b0;
                        t_val     = LD_READ;
                    end
                end
            end
            PH_WSETUP: begin
                if (t_zero) begin
                    r_d.phase = PH_WPULSE;
                    r_d.we_n  = ~(|r_q.lanes);
                    t_load    = 1'b1;
                    t_val     = LD_WLO;
                end
            end
            PH_WPULSE: begin
                if (t_zero) begin
                    r_d.phase = PH_WREC;
                    r_d.we_n  = 1'b1;
                    t_load    = 1'b1;
                    t_val     = LD_WREC;
                end
            end
            PH_WREC: begin
                if (t_zero) begin
                    r_d.phase  = PH_IDLE;
                    r_d.cs_n   = 1'b1;
                    r_d.bsel_n = '1;
                    r_d.drv    = '0;
                    r_d.done   = 1'b1;
                end
            end
            PH_READ: begin
                if (t_zero) begin
                    capture    = 1'b1;
                    r_d.phase  = PH_TURN;
                    r_d.oe_n   = 1'b1;
                    r_d.cs_n   = 1'b1;
                    r_d.bsel_n = '1;
                    t_load     = 1'b1;
                    t_val      = LD_TURN;
                end
            end
            PH_TURN: begin
                if (t_zero) begin
                    r_d.phase = PH_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: begin
                r_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.phase  <= PH_IDLE;
            r_q.cs_n   <= 1'b1;
            r_q.we_n   <= 1'b1;
            r_q.oe_n   <= 1'b1;
            r_q.bsel_n <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    sram16_lane_io u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .lanes   (r_q.lanes),
        .wdata   (r_q.wdata),
        .drv     (r_q.drv),
        .dq_i    (mem_dq_i),
        .dq_o    (mem_dq_o),
        .dq_oe   (mem_dq_oe),
        .rdata   (rd_data)
    );

    assign ready    = (r_q.phase == PH_IDLE);
    assign done     = r_q.done;
    assign mem_addr = r_q.addr;
    assign mem_cs_n = r_q.cs_n;
    assign mem_cs   = r_q.cs;
    assign mem_we_n = r_q.we_n;
    assign mem_oe_n = r_q.oe_n;
    assign mem_lb_n = r_q.bsel_n[0];
    assign mem_ub_n = r_q.bsel_n[LANES-1];

    // Checker counters: cycles with WE low, cycles since OE was last low.
    logic [CNT_W:0] we_lo_cnt, oe_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_cnt <= '0;
            oe_hi_cnt <= '1;
        end else begin
            we_lo_cnt <= mem_we_n ? '0 : we_lo_cnt + 1'b1;
            if (!mem_oe_n)          oe_hi_cnt <= '0;
            else if (oe_hi_cnt != '1) oe_hi_cnt <= oe_hi_cnt + 1'b1;
        end
    end

    AST_WE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_cs && !(mem_lb_n && mem_ub_n))) else $error("WE low without selection"); // R3
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_cnt == (CNT_W+1)'(W_LO))) else $error("write pulse width wrong"); // R3
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_dq_oe == '0)) else $error("bus driven while output enabled"); // R5
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|mem_dq_oe) |-> (oe_hi_cnt >= (CNT_W+1)'(N_TA))) else $error("drive too soon after read"); // R8
    AST_READY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> done) else $error("ready rose without done"); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R10
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)) else $error("address moved while selected"); // R11

endmodule

// File: tb/sram16_strobe_ctrl_tb.sv
`timescale 1ns/1ps
module sram16_strobe_ctrl_tb;

    localparam int PER    = 4;
    localparam int E_CYC  = (70 + PER - 1) / PER;
    localparam int E_OE   = (35 + PER - 1) / PER;
    localparam int E_WP   = (50 + PER - 1) / PER;
    localparam int E_AW   = (60 + PER - 1) / PER;
    localparam int E_DW   = (30 + PER - 1) / PER;
    localparam int E_TA   = 25 / PER + 1;
    localparam int E_WLO  = (E_WP > E_DW) ? E_WP : E_DW;
    localparam int E_WSU  = (E_AW > E_WLO) ? E_AW - E_WLO : 0;
    localparam int E_WREC = (E_CYC > E_WSU + E_WLO) ? E_CYC - E_WSU - E_WLO : 1;
    localparam int E_RLEN = (E_CYC > E_OE) ? E_CYC : E_OE;
    localparam int LAT_WR = E_WSU + E_WLO + E_WREC + 1;
    localparam int LAT_RD = E_RLEN + E_TA + 1;

    typedef struct packed {
        logic        wr;
        logic [19:0] addr;
        logic [15:0] data;
        logic [1:0]  mask;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        {1'b1, 20'h00010, 16'hA5C3, 2'b11, 16'h0000},
        {1'b0, 20'h00010, 16'h0000, 2'b11, 16'hA5C3},
        {1'b1, 20'h00010, 16'h1200, 2'b10, 16'h0000},
        {1'b0, 20'h00010, 16'h0000, 2'b11, 16'h12C3},
        {1'b0, 20'h00010, 16'h0000, 2'b01, 16'h00C3},
        {1'b0, 20'h00010, 16'h0000, 2'b10, 16'h1200},
        {1'b1, 20'h00020, 16'hFFFF, 2'b01, 16'h0000},
        {1'b0, 20'h00020, 16'h0000, 2'b11, 16'h00FF},
        {1'b1, 20'h00020, 16'h5555, 2'b00, 16'h0000},
        {1'b0, 20'h00020, 16'h0000, 2'b11, 16'h00FF},
        {1'b1, 20'hFFFFF, 16'hBEEF, 2'b11, 16'h0000},
        {1'b0, 20'hFFFFF, 16'h0000, 2'b11, 16'hBEEF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_lanes = '0;
    logic        ready, done;
    logic [15:0] rd_data;
    logic [19:0] mem_addr;
    logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
    logic [15:0] mem_dq_o, mem_dq_i;
    logic [1:0]  mem_dq_oe;

    int n_checks = 0;
    int n_err    = 0;

    always #2 clk = ~clk;

    sram16_strobe_ctrl #(.CLK_PERIOD_NS(PER)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_lanes(req_lanes),
        .ready(ready), .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // Memory model: 256 words indexed by the low address byte; 0xEE on a floating lane.
    logic [15:0] model_mem [256];
    logic        rd_ok;
    assign rd_ok = !mem_cs_n && mem_cs && mem_we_n && !mem_oe_n;
    assign mem_dq_i[7:0]  = (rd_ok && !mem_lb_n) ? model_mem[mem_addr[7:0]][7:0]  : 8'hEE;
    assign mem_dq_i[15:8] = (rd_ok && !mem_ub_n) ? model_mem[mem_addr[7:0]][15:8] : 8'hEE;

    always @(posedge mem_we_n) begin
        if (rst_n && !mem_cs_n && mem_cs) begin
            if (!mem_lb_n) model_mem[mem_addr[7:0]][7:0]  <= mem_dq_oe[0] ? mem_dq_o[7:0]  : 8'hDD;
            if (!mem_ub_n) model_mem[mem_addr[7:0]][15:8] <= mem_dq_oe[1] ? mem_dq_o[15:8] : 8'hDD;
        end
    end

    task automatic check_eq(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_ge(input string req, input longint act, input longint lim);
        n_checks++;
        if (act < lim) begin
            n_err++;
            $display("FAIL %s: actual %0d expected at least %0d", req, act, lim);
        end
    endtask

    // Pin monitor
    int   we_run, cs_run, oe_run, drv_run, oe_hi_run;
    int   v_fight, v_wesel, v_addr, v_done, v_lane;
    logic p_we, p_cs_n, p_oe, p_drv, p_done;
    logic [19:0] p_addr;
    bit   lane_seen;

    initial begin
        v_fight = 0; v_wesel = 0; v_addr = 0; v_done = 0; v_lane = 0;
        p_addr = '0;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            we_run = 0; cs_run = 0; oe_run = 0; drv_run = 0; oe_hi_run = 1000;
            p_we = 1'b1; p_cs_n = 1'b1; p_oe = 1'b1; p_drv = 1'b0; p_done = 1'b0;
        end else begin
            if (!p_we && mem_we_n) begin
                check_eq("R3 write pulse width", we_run, E_WLO);
                check_ge("R3 address/select before end of write", cs_run, E_AW);
                check_ge("R4 data driven before end of write", drv_run, E_DW);
                check_eq("R4 data still driven after WE rise", mem_dq_oe != 2'b00, 1);
            end
            if (!p_cs_n && mem_cs_n) check_ge("R2 select time per access", cs_run, E_CYC);
            if (!p_oe && mem_oe_n)   check_ge("R5 output enable window", oe_run, E_RLEN);
            if (!p_drv && (mem_dq_oe != 2'b00)) check_ge("R8 no-drive gap after read", oe_hi_run, E_TA);
            if (!mem_oe_n && (mem_dq_oe != 2'b00)) v_fight++;
            if (!mem_we_n && (mem_cs_n || !mem_cs || (mem_lb_n && mem_ub_n))) v_wesel++;
            if (!p_cs_n && !mem_cs_n && (mem_addr != p_addr)) v_addr++;
            if (p_done && done) v_done++;
            if (!mem_we_n && (mem_dq_oe != ~{mem_ub_n, mem_lb_n})) v_lane++;
            if (!mem_lb_n || !mem_ub_n) lane_seen = 1'b1;
            we_run    = mem_we_n ? 0 : we_run + 1;
            cs_run    = mem_cs_n ? 0 : cs_run + 1;
            oe_run    = mem_oe_n ? 0 : oe_run + 1;
            drv_run   = (mem_dq_oe != 2'b00) ? drv_run + 1 : 0;
            oe_hi_run = mem_oe_n ? oe_hi_run + 1 : 0;
            p_we = mem_we_n; p_cs_n = mem_cs_n; p_oe = mem_oe_n;
            p_drv = (mem_dq_oe != 2'b00); p_done = done; p_addr = mem_addr;
        end
    end

    task automatic do_op(input logic wr, input logic [19:0] a, input logic [15:0] d,
                         input logic [1:0] m, output logic [15:0] rd, output int lat);
        @(negedge clk);
        while (!ready) @(negedge clk);
        lane_seen = 1'b0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_lanes = m;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        rd = rd_data;
    endtask

    task automatic check_idle(input string tag);
        check_eq({tag, " strobes idle high"},
                 {mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'b11111);
        check_eq({tag, " no lane driven"}, mem_dq_oe, 0);
        check_eq({tag, " ready high"}, ready, 1);
    endtask

    initial begin
        logic [15:0] rd;
        int lat;
        for (int i = 0; i < 256; i++) model_mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        check_idle("R1 after reset");
        check_eq("R1 done low after reset", done, 0);
        check_eq("R1 high-active select high", mem_cs, 1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].mask, rd, lat);
            if (VECS[i].wr) begin
                check_eq("R10 write latency", lat, LAT_WR);
                if (VECS[i].mask == 2'b00)
                    check_eq("R7 zero mask left byte selects high", lane_seen, 0);
            end else begin
                check_eq("R10 read latency", lat, LAT_RD);
                check_eq("R5 R6 read data", rd, VECS[i].exp);
            end
            @(negedge clk);
            check_eq("R10 done is a single pulse", done, 0);
            check_idle("R1 between accesses");
        end

        // R9: request while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00030;
        req_wdata = 16'h1111; req_lanes = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        check_eq("R9 ready low while busy", ready, 0);
        req_valid = 1'b1; req_addr = 20'h00040; req_wdata = 16'h2222;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        do_op(1'b0, 20'h00040, 16'h0, 2'b11, rd, lat);
        check_eq("R9 busy request did not write", rd, 16'h0000);
        do_op(1'b0, 20'h00030, 16'h0, 2'b11, rd, lat);
        check_eq("R9 accepted write landed", rd, 16'h1111);

        // R1: reset in the middle of a write
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00050;
        req_wdata = 16'h7777; req_lanes = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 during mid-write reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("R1 after mid-write reset");
        do_op(1'b0, 20'h00020, 16'h0, 2'b11, rd, lat);
        check_eq("R1 R6 read after reset", rd, 16'h00FF);

        // Invariants gathered by the monitor
        check_eq("R5 drive while output enabled", v_fight, 0);
        check_eq("R3 WE low without selection", v_wesel, 0);
        check_eq("R11 address moved while selected", v_addr, 0);
        check_eq("R10 done wider than one cycle", v_done, 0);
        check_eq("R6 driven lanes differ from byte selects", v_lane, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule